// File: doc/BRIEF.md
# PCI Configuration Access Engine

This block turns one configuration-space request (bus, device, function, byte offset, size, write data) into accesses on a 32-bit local bus that reaches an external PCI configuration window. It computes the window select value that steers the bridge, updates the window register, and forms the local-bus address. Bus 0 requests are type 0: the target is picked by a one-hot bit that is split between the window register and the address. Any other bus number gives a type 1 access with bus, device and function packed into the address.

Reads return the addressed bytes shifted down to bit 0 and cut to the requested size. Writes of one or two bytes are done as read-modify-write of the whole dword, while four-byte writes go out directly. A local-bus abort, or a request that fails the size or target checks, ends the access with an error. An aborted read answers with all ones. A cardbus mode input limits the bus to device 0. Requests are taken one at a time through a valid/ready handshake, and each one ends in a single response pulse.

Top module: `cfg_access_engine`

## Requirements
- R1: `req_ready` is high exactly when the block is idle, and a request is taken on a rising edge with `req_valid` and `req_ready` both high. `busy` is high from the next cycle up to the cycle of the response. Every request taken gives exactly one response, a `rsp_valid` pulse one cycle wide. After reset the block is idle, with `win_sel` = 0 and no bus request.
- R2: `req_size` is the byte count. Only 1, 2 and 4 are accepted. Any other value gives a response with `rsp_err`=1 and `rsp_data`=0, makes no local-bus access, and leaves `win_sel` unchanged.
- R3: On bus 0, a device number of 16 or more is rejected in the same way as R2.
- R4: When `cardbus_mode` is high, any device number of 1 or more is rejected in the same way as R2, on every bus.
- R5: For a bus-0 access, `win_sel` = 0x2 | (S & 0xFC000000), where S = 1 << (device+16). `win_sel` is updated before the local-bus request is raised.
- R6: For a bus-0 access, the address is 0x0C000000 | (S & 0x03FFFFFF) | function<<8 | (offset & 0xFC).
- R7: For bus ≠ 0, `win_sel` = 0x3 and the address is 0x0C000000 | bus<<16 | device<<11 | function<<8 | (offset & 0xFC).
- R8: A read returns the dword shifted right by 8×(offset mod 4) and cut to 8, 16 or 32 bits. The bits above the requested size are zero. `rsp_err` is 0.
- R9: A 1- or 2-byte write first reads the dword. It then writes it back with the 0xFF or 0xFFFF mask shifted left by 8×(offset mod 4) (the mask is cut to 32 bits) replaced by the write data shifted the same way. The address is the same for both accesses.
- R10: A 4-byte write makes exactly one local-bus write of `req_wdata` and no read.
- R11: A read that the local bus aborts answers with `rsp_err`=1 and `rsp_data`=0xFFFFFFFF.
- R12: A write that is aborted answers with `rsp_err`=1 and `rsp_data`=0. If the abort comes on the read phase of a read-modify-write, no write access follows.
- R13: `lb_req` stays high, with `lb_addr`, `lb_we` and `lb_wdata` unchanged, until `lb_ack` or `lb_abort` is seen. Each access ends on the edge where one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cardbus_mode | input | 1 | Limit the bus to device 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Byte offset in config space |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response carries an error |
| rsp_data | output | 32 | Read data, right-aligned |
| busy | output | 1 | Request in progress |
| win_sel | output | 32 | Window select register value |
| lb_req | output | 1 | Local-bus access request |
| lb_we | output | 1 | Local-bus write enable |
| lb_addr | output | 32 | Local-bus address |
| lb_wdata | output | 32 | Local-bus write data |
| lb_rdata | input | 32 | Local-bus read data, valid with lb_ack |
| lb_ack | input | 1 | Local-bus completion |
| lb_abort | input | 1 | Local-bus abort completion |

## Verification
The assertions assume that the local bus raises `lb_ack` or `lb_abort` only while `lb_req` is high, never both at once, and for one cycle per access. They also assume `lb_rdata` is valid in that cycle. The bench responder answers on the falling edge after a programmable number of waiting cycles, and it drops its completion the cycle after. It also assumes that request fields are held only while `req_valid` is high. The bench lowers `req_valid` right after the edge that takes the request, so back-to-back requests always pass through idle.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RD    = 2'd2,
    ST_WR    = 2'd3
  } cfg_state_t;

  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;
endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int DW        = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FN_W      = 3,
  parameter int OFF_W     = 8,
  parameter int SEL_SHIFT = 16,
  parameter int SLOT_MAX  = 16,
  parameter logic [DW-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [DW-1:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [DW-1:0] WIN_T0   = 32'h0000_0002,
  parameter logic [DW-1:0] WIN_T1   = 32'h0000_0003
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  func,
  input  logic [OFF_W-1:0] off,
  input  logic             cardbus,
  output logic [DW-1:0]    addr,
  output logic [DW-1:0]    win,
  output logic             tgt_ok
);
  localparam int BUS_SH = 16;
  localparam int DEV_SH = 11;
  localparam int FN_SH  = 8;
  localparam logic [DEV_W:0] SLOT_LIM = (DEV_W+1)'(SLOT_MAX);
  localparam logic [DW-1:0]  DW_ALIGN = ~DW'(3);

  logic          is_t0;
  logic [DW-1:0] sel_bit;
  logic [DW-1:0] low_part;

  always_comb begin
    is_t0    = (bus == '0);
    sel_bit  = DW'(1) << (DW'(SEL_SHIFT) + DW'(dev));
    low_part = (DW'(func) << FN_SH) | (DW'(off) & DW_ALIGN);
    if (is_t0) begin
      win  = WIN_T0 | (sel_bit & WIN_MASK);
      addr = CFG_BASE | (sel_bit & ~WIN_MASK) | low_part;
    end else begin
      win  = WIN_T1;
      addr = CFG_BASE | (DW'(bus) << BUS_SH) | (DW'(dev) << DEV_SH) | low_part;
    end
    tgt_ok = !(cardbus && (dev != '0)) && !(is_t0 && ({1'b0, dev} >= SLOT_LIM));
  end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]           rd_dword,
  input  logic [$clog2(DW/8)-1:0] lane,
  input  logic [2:0]              size,
  input  logic [DW-1:0]           wdata,
  output logic                    size_ok,
  output logic [DW-1:0]           rd_aligned,
  output logic [DW-1:0]           merged
);
  import cfg_access_pkg::*;

  localparam int SH_W = $clog2(DW);
  localparam logic [DW-1:0] MASK_B = DW'(8'hFF);
  localparam logic [DW-1:0] MASK_H = DW'(16'hFFFF);

  logic [SH_W-1:0] sh;
  logic [DW-1:0]   size_mask;
  logic [DW-1:0]   lane_mask;
  logic [DW-1:0]   rd_shift;

  always_comb begin
    sh = SH_W'({lane, 3'b000});
    unique case (size)
      SZ_BYTE: size_mask = MASK_B;
      SZ_HALF: size_mask = MASK_H;
      default: size_mask = '1;
    endcase
    size_ok    = (size == SZ_BYTE) || (size == SZ_HALF) || (size == SZ_WORD);
    rd_shift   = rd_dword >> sh;
    rd_aligned = rd_shift & size_mask;
    lane_mask  = size_mask << sh;
    merged     = (rd_dword & ~lane_mask) | ((wdata & size_mask) << sh);
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int DW    = 32,
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int OFF_W = 8,
  parameter logic [DW-1:0] WIN_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_func,
  input  logic [OFF_W-1:0] req_off,
  input  logic [2:0]       req_size,
  input  logic [DW-1:0]    req_wdata,
  output logic [BUS_W-1:0] q_bus,
  output logic [DEV_W-1:0] q_dev,
  output logic [FN_W-1:0]  q_func,
  output logic [OFF_W-1:0] q_off,
  output logic [2:0]       q_size,
  output logic [DW-1:0]    q_wdata,
  input  logic [DW-1:0]    tgt_addr,
  input  logic [DW-1:0]    tgt_win,
  input  logic             tgt_ok,
  input  logic             size_ok,
  input  logic [DW-1:0]    rd_aligned,
  input  logic [DW-1:0]    merged,
  output logic             busy,
  output logic [DW-1:0]    win_sel,
  output logic             lb_req,
  output logic             lb_we,
  output logic [DW-1:0]    lb_addr,
  output logic [DW-1:0]    lb_wdata,
  input  logic             lb_ack,
  input  logic             lb_abort,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_data
);
  import cfg_access_pkg::*;

  cfg_state_t st;
  logic       q_write;

  assign busy      = (st != ST_IDLE);
  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      q_write   <= 1'b0;
      q_bus     <= '0;
      q_dev     <= '0;
      q_func    <= '0;
      q_off     <= '0;
      q_size    <= '0;
      q_wdata   <= '0;
      win_sel   <= WIN_RST;
      lb_req    <= 1'b0;
      lb_we     <= 1'b0;
      lb_addr   <= '0;
      lb_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            q_write <= req_write;
            q_bus   <= req_bus;
            q_dev   <= req_dev;
            q_func  <= req_func;
            q_off   <= req_off;
            q_size  <= req_size;
            q_wdata <= req_wdata;
            st      <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!size_ok || !tgt_ok) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_data  <= '0;
            st        <= ST_IDLE;
          end else begin
            win_sel <= tgt_win;
            lb_req  <= 1'b1;
            lb_addr <= tgt_addr;
            if (q_write && (q_size == SZ_WORD)) begin
              lb_we    <= 1'b1;
              lb_wdata <= q_wdata;
              st       <= ST_WR;
            end else begin
              lb_we <= 1'b0;
              st    <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (lb_abort) begin
            lb_req    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_data  <= q_write ? '0 : '1;
            st        <= ST_IDLE;
          end else if (lb_ack) begin
            if (q_write) begin
              lb_we    <= 1'b1;
              lb_wdata <= merged;
              st       <= ST_WR;
            end else begin
              lb_req    <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_data  <= rd_aligned;
              st        <= ST_IDLE;
            end
          end
        end
        ST_WR: begin
          if (lb_abort || lb_ack) begin
            lb_req    <= 1'b0;
            lb_we     <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= lb_abort;
            rsp_data  <= '0;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  // R13
  lb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lb_req && !lb_ack && !lb_abort) |=>
      (lb_req && $stable(lb_addr) && $stable(lb_we) && $stable(lb_wdata)));

  // R12
  rmw_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (lb_req && !lb_we && lb_abort) |=> !lb_req);

  // R11
  rd_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD && lb_abort && !q_write) |=>
      (rsp_valid && rsp_err && rsp_data == '1));

  // R1
  lb_idle_chk: assert property (@(posedge clk) disable iff (rst)
    lb_req |-> busy);
endmodule

// File: rtl/cfg_access_engine.sv
module cfg_access_engine #(
  parameter int DW        = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FN_W      = 3,
  parameter int OFF_W     = 8,
  parameter int SEL_SHIFT = 16,
  parameter int SLOT_MAX  = 16,
  parameter logic [DW-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [DW-1:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [DW-1:0] WIN_T0   = 32'h0000_0002,
  parameter logic [DW-1:0] WIN_T1   = 32'h0000_0003,
  parameter logic [DW-1:0] WIN_RST  = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cardbus_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_func,
  input  logic [OFF_W-1:0] req_off,
  input  logic [2:0]       req_size,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_data,
  output logic             busy,
  output logic [DW-1:0]    win_sel,
  output logic             lb_req,
  output logic             lb_we,
  output logic [DW-1:0]    lb_addr,
  output logic [DW-1:0]    lb_wdata,
  input  logic [DW-1:0]    lb_rdata,
  input  logic             lb_ack,
  input  logic             lb_abort
);
  localparam int LANE_W = $clog2(DW/8);
  localparam logic [DW-1:0] SEL_FIELD = ((DW'(1) << SLOT_MAX) - DW'(1)) << SEL_SHIFT;

  logic [BUS_W-1:0] q_bus;
  logic [DEV_W-1:0] q_dev;
  logic [FN_W-1:0]  q_func;
  logic [OFF_W-1:0] q_off;
  logic [2:0]       q_size;
  logic [DW-1:0]    q_wdata;
  logic [DW-1:0]    tgt_addr;
  logic [DW-1:0]    tgt_win;
  logic             tgt_ok;
  logic             size_ok;
  logic [DW-1:0]    rd_aligned;
  logic [DW-1:0]    merged;

  cfg_addr_gen #(
    .DW(DW), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
    .SEL_SHIFT(SEL_SHIFT), .SLOT_MAX(SLOT_MAX), .CFG_BASE(CFG_BASE),
    .WIN_MASK(WIN_MASK), .WIN_T0(WIN_T0), .WIN_T1(WIN_T1)
  ) u_addr (
    .bus(q_bus), .dev(q_dev), .func(q_func), .off(q_off),
    .cardbus(cardbus_mode), .addr(tgt_addr), .win(tgt_win), .tgt_ok(tgt_ok)
  );

  cfg_lane_unit #(.DW(DW)) u_lane (
    .rd_dword(lb_rdata), .lane(q_off[LANE_W-1:0]), .size(q_size),
    .wdata(q_wdata), .size_ok(size_ok), .rd_aligned(rd_aligned), .merged(merged)
  );

  cfg_seq #(
    .DW(DW), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
    .WIN_RST(WIN_RST)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
    .q_bus(q_bus), .q_dev(q_dev), .q_func(q_func), .q_off(q_off),
    .q_size(q_size), .q_wdata(q_wdata),
    .tgt_addr(tgt_addr), .tgt_win(tgt_win), .tgt_ok(tgt_ok),
    .size_ok(size_ok), .rd_aligned(rd_aligned), .merged(merged),
    .busy(busy), .win_sel(win_sel),
    .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_ack(lb_ack), .lb_abort(lb_abort),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  // R5
  t0_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(lb_req) && ((win_sel & ~WIN_MASK) == WIN_T0)) |->
      ($countones((win_sel & WIN_MASK) | (lb_addr & ~WIN_MASK & SEL_FIELD)) == 1));

  // R13
  no_dual_done_chk: assert property (@(posedge clk) disable iff (rst)
    (lb_ack || lb_abort) |-> lb_req);
endmodule

// File: tb/cfg_access_engine_bench.sv
module cfg_access_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cardbus_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_off = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic        busy;
  logic [31:0] win_sel;
  logic        lb_req, lb_we;
  logic [31:0] lb_addr, lb_wdata;
  logic [31:0] lb_rdata = '0;
  logic        lb_ack = 1'b0;
  logic        lb_abort = 1'b0;

  always #4 clk = ~clk;

  cfg_access_engine u_cfg_access_engine (
    .clk(clk), .rst(rst), .cardbus_mode(cardbus_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .busy(busy), .win_sel(win_sel),
    .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_rdata(lb_rdata), .lb_ack(lb_ack), .lb_abort(lb_abort)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // local-bus responder model
  logic [31:0] mem [logic [31:0]];
  int          bus_lat = 0;
  int          abort_at = -1;
  int          wait_cnt = 0;
  int          ntx = 0;
  logic [31:0] log_addr [4];
  logic        log_we [4];
  logic [31:0] log_wdata [4];
  logic [31:0] log_win [4];

  always @(negedge clk) begin
    if (lb_ack || lb_abort) begin
      lb_ack   = 1'b0;
      lb_abort = 1'b0;
    end else if (lb_req) begin
      if (wait_cnt < bus_lat) begin
        wait_cnt++;
      end else begin
        wait_cnt = 0;
        if (ntx < 4) begin
          log_addr[ntx]  = lb_addr;
          log_we[ntx]    = lb_we;
          log_wdata[ntx] = lb_wdata;
          log_win[ntx]   = win_sel;
        end
        if (ntx == abort_at) begin
          lb_abort = 1'b1;
        end else begin
          lb_ack = 1'b1;
          if (lb_we) mem[lb_addr] = lb_wdata;
          else lb_rdata = mem.exists(lb_addr) ? mem[lb_addr] : 32'h0;
        end
        ntx++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] e_win(input logic [7:0] b, input logic [4:0] d);
    if (b == 0) return 32'h2 | ((32'h1 << (d + 16)) & 32'hFC00_0000);
    return 32'h3;
  endfunction

  function automatic logic [31:0] e_addr(input logic [7:0] b, input logic [4:0] d,
                                         input logic [2:0] f, input logic [7:0] o);
    logic [31:0] low = ({29'b0, f} << 8) | {24'b0, o & 8'hFC};
    if (b == 0) return 32'h0C00_0000 | ((32'h1 << (d + 16)) & 32'h03FF_FFFF) | low;
    return 32'h0C00_0000 | ({24'b0, b} << 16) | ({27'b0, d} << 11) | low;
  endfunction

  logic        got_err;
  logic [31:0] got_data;

  task automatic do_req(input logic w, input logic [7:0] b, input logic [4:0] d,
                        input logic [2:0] f, input logic [7:0] o, input logic [2:0] s,
                        input logic [31:0] wd);
    int cyc;
    bit busy_bad;
    ntx = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bus = b; req_dev = d;
    req_func = f; req_off = o; req_size = s; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    busy_bad = 0;
    while (!rsp_valid && cyc < 200) begin
      if (!busy) busy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    chk("R1 response seen", {31'b0, rsp_valid}, 32'h1);
    chk("R1 busy until response", {31'b0, busy_bad}, 32'h0);
    got_err  = rsp_err;
    got_data = rsp_data;
    @(negedge clk);
    chk("R1 single pulse", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 reset ready", {31'b0, req_ready}, 32'h1);
    chk("R1 reset busy", {31'b0, busy}, 32'h0);
    chk("R1 reset lb_req", {31'b0, lb_req}, 32'h0);
    chk("R1 reset win", win_sel, 32'h0);
  endtask

  task automatic t_type0_read;
    mem[e_addr(0, 3, 2, 8'h10)] = 32'hDEAD_BEEF;
    do_req(0, 0, 3, 2, 8'h10, 3'd4, 0);
    chk("R8 word read", got_data, 32'hDEAD_BEEF);
    chk("R8 no err", {31'b0, got_err}, 0);
    chk("R6 t0 addr", log_addr[0], e_addr(0, 3, 2, 8'h10));
    chk("R5 t0 win low dev", log_win[0], e_win(0, 3));
    mem[e_addr(0, 12, 5, 8'h0E)] = 32'h1122_3344;
    do_req(0, 0, 12, 5, 8'h0E, 3'd1, 0);
    chk("R8 byte lane2", got_data, 32'h22);
    chk("R5 t0 win high dev", log_win[0], e_win(0, 12));
    chk("R6 t0 addr high dev", log_addr[0], e_addr(0, 12, 5, 8'h0E));
    chk("R6 one access", ntx, 1);
  endtask

  task automatic t_type1_read;
    bus_lat = 3;
    mem[e_addr(5, 7, 1, 8'h3D)] = 32'h1122_3344;
    do_req(0, 5, 7, 1, 8'h3D, 3'd2, 0);
    chk("R8 half lane1", got_data, 32'h2233);
    chk("R7 t1 addr", log_addr[0], e_addr(5, 7, 1, 8'h3D));
    chk("R7 t1 win", win_sel, 32'h3);
    chk("R13 one access under wait", ntx, 1);
    mem[e_addr(9, 31, 7, 8'hFF)] = 32'hA1B2_C3D4;
    do_req(0, 9, 31, 7, 8'hFF, 3'd2, 0);
    chk("R8 half at lane3", got_data, 32'h00A1);
    chk("R7 t1 addr max fields", log_addr[0], e_addr(9, 31, 7, 8'hFF));
    bus_lat = 0;
  endtask

  task automatic t_sub_write;
    logic [31:0] a = e_addr(0, 4, 0, 8'h21);
    mem[a] = 32'hA1B2_C3D4;
    do_req(1, 0, 4, 0, 8'h21, 3'd1, 32'hFFFF_FF5E);
    chk("R9 two accesses", ntx, 2);
    chk("R9 read first", {31'b0, log_we[0]}, 0);
    chk("R9 write second", {31'b0, log_we[1]}, 1);
    chk("R9 same addr", log_addr[1], a);
    chk("R9 byte merge", mem[a], 32'hA1B2_5ED4);
    chk("R12 write data zero", got_data, 0);
    mem[a] = 32'hA1B2_C3D4;
    do_req(1, 0, 4, 0, 8'h22, 3'd2, 32'h0000_9876);
    chk("R9 half merge", mem[a], 32'h9876_C3D4);
    mem[a] = 32'hA1B2_C3D4;
    do_req(1, 0, 4, 0, 8'h23, 3'd2, 32'h0000_1234);
    chk("R9 half at lane3 clipped", mem[a], 32'h34B2_C3D4);
  endtask

  task automatic t_full_write;
    logic [31:0] a = e_addr(3, 2, 6, 8'h40);
    do_req(1, 3, 2, 6, 8'h40, 3'd4, 32'hCAFE_F00D);
    chk("R10 single access", ntx, 1);
    chk("R10 is write", {31'b0, log_we[0]}, 1);
    chk("R10 data", mem[a], 32'hCAFE_F00D);
    chk("R10 no err", {31'b0, got_err}, 0);
  endtask

  task automatic t_invalid;
    logic [31:0] w0;
    do_req(0, 0, 1, 0, 8'h00, 3'd4, 0);
    w0 = win_sel;
    do_req(0, 0, 1, 0, 8'h00, 3'd3, 0);
    chk("R2 size3 err", {31'b0, got_err}, 1);
    chk("R2 size3 data", got_data, 0);
    chk("R2 no access", ntx, 0);
    chk("R2 win kept", win_sel, w0);
    do_req(1, 0, 1, 0, 8'h00, 3'd0, 0);
    chk("R2 size0 err", {31'b0, got_err}, 1);
    do_req(0, 0, 16, 0, 8'h00, 3'd4, 0);
    chk("R3 dev16 err", {31'b0, got_err}, 1);
    chk("R3 no access", ntx, 0);
    do_req(0, 0, 15, 0, 8'h00, 3'd4, 0);
    chk("R3 dev15 ok", {31'b0, got_err}, 0);
    chk("R5 dev15 win", win_sel, e_win(0, 15));
    do_req(0, 1, 20, 0, 8'h00, 3'd4, 0);
    chk("R3 t1 dev20 ok", {31'b0, got_err}, 0);
    cardbus_mode = 1'b1;
    do_req(0, 0, 1, 0, 8'h00, 3'd4, 0);
    chk("R4 cardbus dev1 err", {31'b0, got_err}, 1);
    chk("R4 no access", ntx, 0);
    do_req(0, 2, 1, 0, 8'h00, 3'd4, 0);
    chk("R4 cardbus bus2 dev1 err", {31'b0, got_err}, 1);
    do_req(0, 0, 0, 0, 8'h00, 3'd4, 0);
    chk("R4 cardbus dev0 ok", {31'b0, got_err}, 0);
    cardbus_mode = 1'b0;
  endtask

  task automatic t_abort;
    logic [31:0] a = e_addr(0, 6, 0, 8'h08);
    abort_at = 0;
    do_req(0, 0, 6, 0, 8'h08, 3'd1, 0);
    chk("R11 abort err", {31'b0, got_err}, 1);
    chk("R11 abort ones", got_data, 32'hFFFF_FFFF);
    mem[a] = 32'h5555_AAAA;
    do_req(1, 0, 6, 0, 8'h08, 3'd2, 32'h1234);
    chk("R12 rmw abort err", {31'b0, got_err}, 1);
    chk("R12 rmw no write", ntx, 1);
    chk("R12 mem intact", mem[a], 32'h5555_AAAA);
    abort_at = 1;
    do_req(1, 0, 6, 0, 8'h08, 3'd1, 32'h77);
    chk("R12 write phase abort err", {31'b0, got_err}, 1);
    chk("R12 write phase data", got_data, 0);
    abort_at = 0;
    do_req(1, 0, 6, 0, 8'h08, 3'd4, 32'h1);
    chk("R12 full write abort", {31'b0, got_err}, 1);
    abort_at = -1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_type0_read;
    t_type1_read;
    t_sub_write;
    t_full_write;
    t_invalid;
    t_abort;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule